// File: doc/BRIEF.md
# Fuse Macro Auto-Access Sequencer

This block runs a one-time-programmable fuse macro through one complete access at a time: either a read of a 32-bit word or the blowing of one single bit. Software sets up the access through a small word-addressed register file and starts it by setting an enable bit. The sequencer then drives the macro's chip-select, program-enable, load, address and strobe pins. Each pin has its own programmable start offset and pulse length, counted in clock cycles from the first cycle of the access. There is one set of timings for reads and another for programming.

The fuse array is split into a protected lower region and an open upper region. Every start comes with a security attribute. An access whose attribute does not match the region of its target word is refused: no pin moves and an error status bit is raised. A finished access raises a completion status bit. All status bits are write-one-to-clear and can each be routed to a single level interrupt. A behavioural array port gives the operation address to an array model, takes back the addressed word, and signals each bit to be blown with a one-cycle pulse.

Top module: `fuse_auto_seq`

## Requirements
- R1: After reset all macro pins are idle (chip-select and program-enable high, load and strobe low, macro address zero), status, interrupt enable and data-out read zero, and the timing registers read back {start,length} of {1,4} for chip-select, program-enable, load and address and {2,3} for strobe in the read set, and {1,241} and {2,240} in the program set.
- R2: Register 0 bit 0 selects user mode (1) or sequenced mode (0); while it is 1, writes to the control register (register 1) are dropped entirely: no access starts, no status changes and the control register keeps its value.
- R3: The control register (register 1) holds enable in bit 0, read (1) or program (0) in bit 1 and the 10-bit fuse address in bits 25:16. An access starts only on a write that sets enable while the stored enable is 0 and no access is running; writing enable again without first clearing it starts nothing.
- R4: Timing registers 5 to 9 (read set) and 10 to 14 (program set) serve chip-select, program-enable, load, address and strobe in that order, each with start in bits 31:16 and length in bits 15:0. With cycle 0 being the first cycle after the accepting clock edge, a pin is asserted exactly in the cycles n with start <= n < start+length. Chip-select and program-enable are asserted low, load and strobe high.
- R5: An access lasts E cycles, E being the largest start+length of its timing set. Status bit 0 (finish) reads 1 from cycle E onward, and all pins are idle from cycle E.
- R6: A read captures the array word at the operation address into data-out (register 4), sampled in the last strobe cycle. Reads of word addresses in both regions return the stored word.
- R7: A program access with address w + 32*b pulses the bit-blow output for exactly one cycle, the last strobe cycle, so that bit b of word w becomes 1; other bits are untouched.
- R8: Words 0 to 23 (address bits 4:0) are protected. A start with the attribute low aimed at words 0 to 23 sets status bit 1; a start with the attribute high aimed at words 24 to 31 sets status bit 2. Neither starts an access, moves a pin, sets finish or changes data-out.
- R9: Status (register 3) is cleared per bit by writing 1, and a bit written 0 is kept. The interrupt output is high whenever a status bit is set whose bit in the enable register (register 2) is also set.
- R10: The macro address pins carry the operation address only while the address pulse is active and are zero otherwise; the array-model address output carries the operation address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr | input | 1 | Register write strobe |
| reg_waddr | input | 4 | Register write word index |
| reg_wdata | input | 32 | Register write data |
| reg_raddr | input | 4 | Register read word index |
| reg_rdata | output | 32 | Register read data (combinational) |
| sec_in | input | 1 | Security attribute of the write that starts an access |
| irq | output | 1 | Level interrupt |
| mac_csb_n | output | 1 | Macro chip-select, active low |
| mac_pgenb_n | output | 1 | Macro program-enable, active low |
| mac_load | output | 1 | Macro load, active high |
| mac_strobe | output | 1 | Macro strobe, active high |
| mac_addr | output | 10 | Macro address pins |
| fa_addr | output | 10 | Operation address to the array model |
| fa_rdata | input | 32 | Word returned by the array model |
| fa_prog | output | 1 | One-cycle bit-blow pulse to the array model |

## Verification
The main function is exercised with reads under the default timings, with a custom read timing set where chip-select begins in cycle 0 and strobe ends on the last cycle, and with program accesses to a low bit of a protected word and to the top bit of the last open word. The default read separates an off-by-one error in the finish cycle, the custom set separates use of the wrong timing set or a wrong pulse window, and the two programs separate the word and bit fields of the folded address. Mismatched attributes in both directions, a repeated enable, user mode and partial status clears show that each refused input leaves pins, data-out and status untouched. A cycle-level model in the bench compares every pin, the blow pulse and the interrupt on every clock.

// File: rtl/fas_pkg.sv
package fas_pkg;
   // timing field width (start and length each)
   localparam int TW = 16;
   // macro control pins driven by the sequencer
   localparam int NPIN       = 5;
   localparam int PIN_CSB    = 0;
   localparam int PIN_PGENB  = 1;
   localparam int PIN_LOAD   = 2;
   localparam int PIN_ADDR   = 3;
   localparam int PIN_STROBE = 4;
   // pins that are asserted low at the macro
   localparam logic [NPIN-1:0] PIN_ACT_LOW = 5'b00011;

   // register word indices
   localparam int REG_MODE = 0;
   localparam int REG_CTRL = 1;
   localparam int REG_IEN  = 2;
   localparam int REG_STAT = 3;
   localparam int REG_DOUT = 4;
   localparam int REG_TRD  = 5;
   localparam int REG_TPG  = REG_TRD + NPIN;

   // status bits
   localparam int ST_DONE = 0;
   localparam int ST_NS2S = 1;
   localparam int ST_S2NS = 2;
   localparam int NSTAT   = 3;

   typedef struct packed {
      logic [TW-1:0] start;
      logic [TW-1:0] len;
   } tim_t;

   function automatic tim_t tim_default(input logic rd, input int pin);
      tim_t t;
      t.start = (pin == PIN_STROBE) ? TW'(2) : TW'(1);
      if (rd) t.len = (pin == PIN_STROBE) ? TW'(3) : TW'(4);
      else    t.len = (pin == PIN_STROBE) ? TW'(240) : TW'(241);
      return t;
   endfunction
endpackage

// File: rtl/fas_regs.sv
module fas_regs
   import fas_pkg::*;
#(
   parameter int ADDR_W = 10,
   parameter int DATA_W = 32,
   parameter int REG_AW = 4
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    wr,
   input  logic [REG_AW-1:0]       waddr,
   input  logic [DATA_W-1:0]       wdata,
   input  logic [REG_AW-1:0]       raddr,
   output logic [DATA_W-1:0]       rdata,
   input  logic                    busy,
   input  logic [NSTAT-1:0]        set_stat,
   input  logic                    dout_we,
   input  logic [DATA_W-1:0]       dout_in,
   output logic                    mode_user,
   output logic                    start_req,
   output logic                    start_rd,
   output logic [ADDR_W-1:0]       start_addr,
   output tim_t [NPIN-1:0]         rd_tim,
   output tim_t [NPIN-1:0]         pg_tim,
   output logic [NSTAT-1:0]        stat,
   output logic                    irq
);
   localparam int A_LSB = 16;

   logic              mode_q;
   logic              ctrl_en_q, ctrl_rd_q;
   logic [ADDR_W-1:0] ctrl_addr_q;
   logic [NSTAT-1:0]  ien_q, stat_q, clr;
   logic [DATA_W-1:0] dout_q;
   tim_t              rd_q [NPIN];
   tim_t              pg_q [NPIN];
   logic              hit_ctrl, ctrl_acc;
   logic              unused_wbits;

   assign unused_wbits = ^wdata;
   assign hit_ctrl   = wr && (waddr == REG_AW'(REG_CTRL));
   assign ctrl_acc   = hit_ctrl && !mode_q && !busy;
   assign start_req  = ctrl_acc && wdata[0] && !ctrl_en_q;
   assign start_rd   = wdata[1];
   assign start_addr = wdata[A_LSB +: ADDR_W];
   assign clr        = (wr && (waddr == REG_AW'(REG_STAT))) ? wdata[NSTAT-1:0] : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q      <= 1'b0;
         ctrl_en_q   <= 1'b0;
         ctrl_rd_q   <= 1'b0;
         ctrl_addr_q <= '0;
         ien_q       <= '0;
         stat_q      <= '0;
         dout_q      <= '0;
      end else begin
         if (wr && (waddr == REG_AW'(REG_MODE))) mode_q <= wdata[0];
         if (ctrl_acc) begin
            ctrl_en_q   <= wdata[0];
            ctrl_rd_q   <= wdata[1];
            ctrl_addr_q <= wdata[A_LSB +: ADDR_W];
         end
         if (wr && (waddr == REG_AW'(REG_IEN))) ien_q <= wdata[NSTAT-1:0];
         // hardware set wins over a same-cycle clear
         stat_q <= (stat_q & ~clr) | set_stat;
         if (dout_we) dout_q <= dout_in;
      end
   end

   for (genvar i = 0; i < NPIN; i++) begin : g_tim
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            rd_q[i] <= tim_default(1'b1, i);
            pg_q[i] <= tim_default(1'b0, i);
         end else if (wr) begin
            if (waddr == REG_AW'(REG_TRD + i)) rd_q[i] <= tim_t'(wdata[2*TW-1:0]);
            if (waddr == REG_AW'(REG_TPG + i)) pg_q[i] <= tim_t'(wdata[2*TW-1:0]);
         end
      end
      assign rd_tim[i] = rd_q[i];
      assign pg_tim[i] = pg_q[i];
   end

   always_comb begin
      rdata = '0;
      if (raddr == REG_AW'(REG_MODE)) rdata[0] = mode_q;
      if (raddr == REG_AW'(REG_CTRL)) begin
         rdata[0] = ctrl_en_q;
         rdata[1] = ctrl_rd_q;
         rdata[A_LSB +: ADDR_W] = ctrl_addr_q;
      end
      if (raddr == REG_AW'(REG_IEN))  rdata[NSTAT-1:0] = ien_q;
      if (raddr == REG_AW'(REG_STAT)) rdata[NSTAT-1:0] = stat_q;
      if (raddr == REG_AW'(REG_DOUT)) rdata = dout_q;
      for (int i = 0; i < NPIN; i++) begin
         if (raddr == REG_AW'(REG_TRD + i)) rdata[2*TW-1:0] = rd_q[i];
         if (raddr == REG_AW'(REG_TPG + i)) rdata[2*TW-1:0] = pg_q[i];
      end
   end

   assign mode_user = mode_q;
   assign stat      = stat_q;
   assign irq       = |(stat_q & ien_q);
endmodule

// File: rtl/fas_pulse.sv
module fas_pulse
   import fas_pkg::*;
#(
   parameter int CW = TW + 1
) (
   input  logic          run,
   input  logic [CW-1:0] cnt,
   input  tim_t          tim,
   output logic          active,
   output logic          last
);
   logic [CW-1:0] t_on, t_off;

   assign t_on   = CW'(tim.start);
   assign t_off  = CW'(tim.start) + CW'(tim.len);
   assign active = run && (cnt >= t_on) && (cnt < t_off);
   assign last   = run && (tim.len != '0) && (cnt == t_off - CW'(1));
endmodule

// File: rtl/fas_fsm.sv
module fas_fsm
   import fas_pkg::*;
#(
   parameter int ADDR_W    = 10,
   parameter int DATA_W    = 32,
   parameter int WORDS     = 32,
   parameter int SEC_WORDS = 24
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start_req,
   input  logic               start_rd,
   input  logic [ADDR_W-1:0]  start_addr,
   input  logic               sec_in,
   input  tim_t [NPIN-1:0]    rd_tim,
   input  tim_t [NPIN-1:0]    pg_tim,
   output logic               busy,
   output logic [NSTAT-1:0]   set_stat,
   output logic               dout_we,
   output logic               prog,
   output logic [NPIN-1:0]    act,
   output logic [ADDR_W-1:0]  op_addr
);
   localparam int WORD_W = $clog2(WORDS);
   localparam int CW     = TW + 1;
   localparam logic [WORD_W:0] SEC_LIM = (WORD_W+1)'(SEC_WORDS);

   logic              busy_q, op_rd_q;
   logic [CW-1:0]     cnt_q, end_v;
   logic [ADDR_W-1:0] op_addr_q;
   tim_t [NPIN-1:0]   sel;
   logic [NPIN-1:0]   last;
   logic              fin, in_sec, viol_ns, viol_s, go;

   assign sel = op_rd_q ? rd_tim : pg_tim;

   always_comb begin
      end_v = '0;
      for (int i = 0; i < NPIN; i++)
         if (CW'(sel[i].start) + CW'(sel[i].len) > end_v)
            end_v = CW'(sel[i].start) + CW'(sel[i].len);
   end

   assign fin     = busy_q && (({1'b0, cnt_q} + (CW+1)'(1)) >= {1'b0, end_v});
   assign in_sec  = {1'b0, start_addr[WORD_W-1:0]} < SEC_LIM;
   assign viol_ns = !sec_in && in_sec;
   assign viol_s  = sec_in && !in_sec;
   assign go      = start_req && !viol_ns && !viol_s;

   always_comb begin
      set_stat          = '0;
      set_stat[ST_DONE] = fin;
      set_stat[ST_NS2S] = start_req && viol_ns;
      set_stat[ST_S2NS] = start_req && viol_s;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q    <= 1'b0;
         cnt_q     <= '0;
         op_rd_q   <= 1'b0;
         op_addr_q <= '0;
      end else if (go) begin
         busy_q    <= 1'b1;
         cnt_q     <= '0;
         op_rd_q   <= start_rd;
         op_addr_q <= start_addr;
      end else if (fin) begin
         busy_q <= 1'b0;
      end else if (busy_q) begin
         cnt_q <= cnt_q + CW'(1);
      end
   end

   for (genvar i = 0; i < NPIN; i++) begin : g_pin
      fas_pulse #(.CW(CW)) i_pulse (
         .run    (busy_q),
         .cnt    (cnt_q),
         .tim    (sel[i]),
         .active (act[i]),
         .last   (last[i])
      );
   end

   assign busy    = busy_q;
   assign op_addr = op_addr_q;
   assign dout_we = busy_q && op_rd_q && last[PIN_STROBE];
   assign prog    = busy_q && !op_rd_q && last[PIN_STROBE];
endmodule

// File: rtl/fuse_auto_seq.sv
module fuse_auto_seq
   import fas_pkg::*;
#(
   parameter int ADDR_W    = 10,
   parameter int DATA_W    = 32,
   parameter int REG_AW    = 4,
   parameter int WORDS     = 32,
   parameter int SEC_WORDS = 24
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [REG_AW-1:0] reg_waddr,
   input  logic [DATA_W-1:0] reg_wdata,
   input  logic [REG_AW-1:0] reg_raddr,
   output logic [DATA_W-1:0] reg_rdata,
   input  logic              sec_in,
   output logic              irq,
   output logic              mac_csb_n,
   output logic              mac_pgenb_n,
   output logic              mac_load,
   output logic              mac_strobe,
   output logic [ADDR_W-1:0] mac_addr,
   output logic [ADDR_W-1:0] fa_addr,
   input  logic [DATA_W-1:0] fa_rdata,
   output logic              fa_prog
);
   localparam int WORD_W = $clog2(WORDS);

   if ((1 << WORD_W) != WORDS) begin : g_bad_words
      $error("WORDS must be a power of two");
   end
   if (SEC_WORDS > WORDS) begin : g_bad_sec
      $error("SEC_WORDS must not exceed WORDS");
   end
   if (ADDR_W < WORD_W) begin : g_bad_addr
      $error("ADDR_W too small for WORDS");
   end
   if (DATA_W < 16 + ADDR_W || DATA_W < 2 * TW) begin : g_bad_data
      $error("DATA_W too small for control or timing fields");
   end
   if ((1 << REG_AW) < REG_TPG + NPIN) begin : g_bad_regaw
      $error("REG_AW too small for the register map");
   end

   logic              busy, mode_user, start_req, start_rd, dout_we;
   logic [ADDR_W-1:0] start_addr, op_addr;
   logic [NSTAT-1:0]  stat, set_stat;
   tim_t [NPIN-1:0]   rd_tim, pg_tim;
   logic [NPIN-1:0]   act, lvl;

   fas_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .REG_AW(REG_AW)) i_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr         (reg_wr),
      .waddr      (reg_waddr),
      .wdata      (reg_wdata),
      .raddr      (reg_raddr),
      .rdata      (reg_rdata),
      .busy       (busy),
      .set_stat   (set_stat),
      .dout_we    (dout_we),
      .dout_in    (fa_rdata),
      .mode_user  (mode_user),
      .start_req  (start_req),
      .start_rd   (start_rd),
      .start_addr (start_addr),
      .rd_tim     (rd_tim),
      .pg_tim     (pg_tim),
      .stat       (stat),
      .irq        (irq)
   );

   fas_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .WORDS(WORDS), .SEC_WORDS(SEC_WORDS)) i_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .start_req  (start_req),
      .start_rd   (start_rd),
      .start_addr (start_addr),
      .sec_in     (sec_in),
      .rd_tim     (rd_tim),
      .pg_tim     (pg_tim),
      .busy       (busy),
      .set_stat   (set_stat),
      .dout_we    (dout_we),
      .prog       (fa_prog),
      .act        (act),
      .op_addr    (op_addr)
   );

   // polarity per pin chosen at elaboration
   for (genvar i = 0; i < NPIN; i++) begin : g_pol
      if (PIN_ACT_LOW[i]) begin : g_low
         assign lvl[i] = ~act[i];
      end else begin : g_high
         assign lvl[i] = act[i];
      end
   end

   assign mac_csb_n   = lvl[PIN_CSB];
   assign mac_pgenb_n = lvl[PIN_PGENB];
   assign mac_load    = lvl[PIN_LOAD];
   assign mac_strobe  = lvl[PIN_STROBE];
   assign mac_addr    = act[PIN_ADDR] ? op_addr : '0;
   assign fa_addr     = op_addr;
endmodule

// File: rtl/fas_checker.sv
module fas_checker #(
   parameter int ADDR_W = 10
) (
   input logic              clk,
   input logic              rst_n,
   input logic              busy,
   input logic              mode_user,
   input logic [2:0]        stat,
   input logic              mac_csb_n,
   input logic              mac_pgenb_n,
   input logic              mac_load,
   input logic              mac_strobe,
   input logic [ADDR_W-1:0] mac_addr,
   input logic              fa_prog
);
   p_idle_pins_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (mac_csb_n && mac_pgenb_n && !mac_load && !mac_strobe));

   p_user_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_user && !busy) |=> !busy);

   p_finish_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> stat[0]);

   p_prog_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
      fa_prog |=> !fa_prog);

   p_prog_in_strobe_r7: assert property (@(posedge clk) disable iff (!rst_n)
      fa_prog |-> (mac_strobe && busy));

   p_abort_no_run_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(stat[1]) |-> !busy);

   p_addr_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (mac_addr == '0));
endmodule

bind fuse_auto_seq fas_checker #(.ADDR_W(ADDR_W)) i_fas_checker (
   .clk         (clk),
   .rst_n       (rst_n),
   .busy        (busy),
   .mode_user   (mode_user),
   .stat        (stat),
   .mac_csb_n   (mac_csb_n),
   .mac_pgenb_n (mac_pgenb_n),
   .mac_load    (mac_load),
   .mac_strobe  (mac_strobe),
   .mac_addr    (mac_addr),
   .fa_prog     (fa_prog)
);

// File: tb/test_fuse_auto_seq.sv
`timescale 1ns/1ps
module test_fuse_auto_seq;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [3:0]  reg_waddr = '0;
   logic [31:0] reg_wdata = '0;
   logic [3:0]  reg_raddr = '0;
   logic [31:0] reg_rdata;
   logic        sec_in = 1'b0;
   logic        irq, mac_csb_n, mac_pgenb_n, mac_load, mac_strobe, fa_prog;
   logic [9:0]  mac_addr, fa_addr;
   logic [31:0] fa_rdata;
   logic [31:0] fmem [32];

   always #5 clk = ~clk;

   assign fa_rdata = fmem[fa_addr[4:0]];

   fuse_auto_seq i_fuse_auto_seq (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_waddr(reg_waddr),
      .reg_wdata(reg_wdata), .reg_raddr(reg_raddr), .reg_rdata(reg_rdata),
      .sec_in(sec_in), .irq(irq), .mac_csb_n(mac_csb_n), .mac_pgenb_n(mac_pgenb_n),
      .mac_load(mac_load), .mac_strobe(mac_strobe), .mac_addr(mac_addr),
      .fa_addr(fa_addr), .fa_rdata(fa_rdata), .fa_prog(fa_prog)
   );

   int nchk = 0;
   int nfail = 0;
   bit done = 0;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      nchk++;
      if (act !== exp) begin
         nfail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // ---------------- behavioural reference model ----------------
   int  rs [5], rl [5], ps [5], pl [5];
   bit  m_run, m_rd, m_mode, m_en, m_crd;
   int  m_cnt, m_addr, m_caddr, m_ien, m_stat;
   logic [31:0] m_dout;

   function automatic int tstart(int i);
      return m_rd ? rs[i] : ps[i];
   endfunction
   function automatic int tlen(int i);
      return m_rd ? rl[i] : pl[i];
   endfunction
   function automatic bit pact(int i);
      return m_run && m_cnt >= tstart(i) && m_cnt < tstart(i) + tlen(i);
   endfunction

   always @(posedge clk) begin
      int endv, nstat, w;
      bit fin, last, was_run;
      if (!rst_n) begin
         for (int i = 0; i < 5; i++) begin
            rs[i] = 1; rl[i] = 4; ps[i] = 1; pl[i] = 241;
         end
         rs[4] = 2; rl[4] = 3; ps[4] = 2; pl[4] = 240;
         m_run = 0; m_rd = 0; m_mode = 0; m_en = 0; m_crd = 0;
         m_cnt = 0; m_addr = 0; m_caddr = 0; m_ien = 0; m_stat = 0; m_dout = 0;
      end else begin
         endv = 0;
         for (int i = 0; i < 5; i++)
            if (tstart(i) + tlen(i) > endv) endv = tstart(i) + tlen(i);
         fin  = m_run && (m_cnt + 1 >= endv);
         last = m_run && tlen(4) > 0 && m_cnt == tstart(4) + tlen(4) - 1;
         if (last && m_rd)  m_dout = fmem[m_addr % 32];
         if (last && !m_rd) fmem[m_addr % 32][m_addr / 32] = 1'b1;
         was_run = m_run;
         nstat = m_stat;
         if (fin) m_run = 0;
         else if (m_run) m_cnt++;
         if (reg_wr) begin
            if (reg_waddr == 0) m_mode = reg_wdata[0];
            if (reg_waddr == 1 && !m_mode && !was_run) begin
               if (reg_wdata[0] && !m_en) begin
                  w = int'(reg_wdata[20:16]);
                  if (!sec_in && w < 24)      nstat |= 2;
                  else if (sec_in && w >= 24) nstat |= 4;
                  else begin
                     m_run = 1; m_cnt = 0; m_rd = reg_wdata[1];
                     m_addr = int'(reg_wdata[25:16]);
                  end
               end
               m_en = reg_wdata[0]; m_crd = reg_wdata[1]; m_caddr = int'(reg_wdata[25:16]);
            end
            if (reg_waddr == 2) m_ien = int'(reg_wdata[2:0]);
            if (reg_waddr == 3) nstat &= ~int'(reg_wdata[2:0]);
            if (reg_waddr >= 5 && reg_waddr <= 9) begin
               rs[reg_waddr-5] = int'(reg_wdata[31:16]); rl[reg_waddr-5] = int'(reg_wdata[15:0]);
            end
            if (reg_waddr >= 10 && reg_waddr <= 14) begin
               ps[reg_waddr-10] = int'(reg_wdata[31:16]); pl[reg_waddr-10] = int'(reg_wdata[15:0]);
            end
         end
         if (fin) nstat |= 1;
         m_stat = nstat;
      end
   end

   // every-cycle comparison against the model
   always @(negedge clk) begin
      if (rst_n && !done) begin
         chk("R4 chip-select/program-enable pins", {30'd0, mac_csb_n, mac_pgenb_n},
             {30'd0, !pact(0), !pact(1)});
         chk("R4 load/strobe pins", {30'd0, mac_load, mac_strobe}, {30'd0, pact(2), pact(4)});
         chk("R10 macro address", {22'd0, mac_addr}, pact(3) ? 32'(m_addr) : 32'd0);
         chk("R7 blow pulse", {31'd0, fa_prog},
             {31'd0, m_run && !m_rd && tlen(4) > 0 && m_cnt == tstart(4) + tlen(4) - 1});
         chk("R9 interrupt", {31'd0, irq}, {31'd0, (m_stat & m_ien) != 0});
      end
   end

   // ---------------- stimulus helpers ----------------
   function automatic logic [31:0] ctl(int a, bit rd, bit en);
      return (32'(a) << 16) | (32'(rd) << 1) | 32'(en);
   endfunction

   task automatic wr(input int a, input logic [31:0] d, input bit s);
      @(negedge clk);
      reg_wr = 1'b1; reg_waddr = 4'(a); reg_wdata = d; sec_in = s;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rdc(input int a, input logic [31:0] exp, input string tag);
      reg_raddr = 4'(a);
      #1;
      chk(tag, reg_rdata, exp);
   endtask

   task automatic wait_idle();
      int n = 0;
      while (m_run && n < 2000) begin
         @(negedge clk);
         n++;
      end
      @(negedge clk);
   endtask

   logic [31:0] orig3, orig31;

   initial begin
      for (int i = 0; i < 32; i++) fmem[i] = (32'(i) * 32'h0103_0507 + 32'h1100_0000) & ~32'h8000_0080;
      orig3 = fmem[3];
      orig31 = fmem[31];
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      chk("R1 idle pins", {28'd0, mac_csb_n, mac_pgenb_n, mac_load, mac_strobe}, 32'hC);
      rdc(3, 0, "R1 status");
      rdc(4, 0, "R1 data-out");
      rdc(5, 32'h0001_0004, "R1 read chip-select timing");
      rdc(9, 32'h0002_0003, "R1 read strobe timing");
      rdc(10, 32'h0001_00F1, "R1 program chip-select timing");
      rdc(14, 32'h0002_00F0, "R1 program strobe timing");

      wr(2, 7, 0);
      // R3/R5/R6 default read of protected word 5
      wr(1, ctl(5, 1, 1), 1);
      rdc(1, ctl(5, 1, 1), "R3 control readback");
      repeat (4) @(negedge clk);
      rdc(3, 0, "R5 finish not before cycle E");
      @(negedge clk);
      rdc(3, 1, "R5 finish at cycle E");
      rdc(4, fmem[5], "R6 read word 5");

      // R3 repeated enable starts nothing
      wr(3, 7, 0);
      wr(1, ctl(6, 1, 1), 1);
      repeat (10) @(negedge clk);
      rdc(3, 0, "R3 no start without clearing enable");
      rdc(4, fmem[5], "R3 data-out unchanged");

      // R6 read of open word 30
      wr(1, 0, 0);
      wr(1, ctl(30, 1, 1), 0);
      wait_idle();
      rdc(3, 1, "R6 finish open read");
      rdc(4, fmem[30], "R6 read word 30");
      wr(3, 1, 0);
      wr(1, 0, 0);

      // R7 program bit 7 of word 3, then bit 31 of word 31
      wr(1, ctl(3 + 32 * 7, 0, 1), 1);
      wait_idle();
      wr(3, 1, 0); wr(1, 0, 0);
      wr(1, ctl(3, 1, 1), 1);
      wait_idle();
      rdc(4, orig3 | 32'h80, "R7 bit 7 of word 3 blown");
      wr(3, 1, 0); wr(1, 0, 0);
      wr(1, ctl(31 + 32 * 31, 0, 1), 0);
      wait_idle();
      wr(3, 1, 0); wr(1, 0, 0);
      wr(1, ctl(31, 1, 1), 0);
      wait_idle();
      rdc(4, orig31 | 32'h8000_0000, "R7 bit 31 of word 31 blown");
      wr(3, 1, 0); wr(1, 0, 0);

      // R8 region violations in both directions
      wr(1, ctl(2, 1, 1), 0);
      repeat (3) @(negedge clk);
      rdc(3, 2, "R8 open attribute to protected word");
      wr(1, 0, 0);
      wr(1, ctl(26, 1, 1), 1);
      repeat (3) @(negedge clk);
      rdc(3, 6, "R8 protected attribute to open word");
      rdc(4, orig31 | 32'h8000_0000, "R8 data-out unchanged");
      // R9 partial clear
      wr(3, 2, 0);
      rdc(3, 4, "R9 clear bit 1 keeps bit 2");
      wr(3, 4, 0);
      rdc(3, 0, "R9 all clear");
      wr(1, 0, 0);

      // R2 user mode drops control writes
      wr(0, 1, 0);
      rdc(0, 1, "R2 mode readback");
      wr(1, ctl(5, 1, 1), 1);
      repeat (20) @(negedge clk);
      rdc(3, 0, "R2 no access in user mode");
      rdc(1, 0, "R2 control unchanged in user mode");
      wr(0, 0, 0);

      // R4 custom read timing set
      wr(5, 32'h0000_000A, 0);
      wr(6, 32'h0003_0002, 0);
      wr(7, 32'h0005_0001, 0);
      wr(8, 32'h0002_0006, 0);
      wr(9, 32'h0007_0003, 0);
      rdc(8, 32'h0002_0006, "R4 timing readback");
      wr(1, ctl(12, 1, 1), 1);
      chk("R4 chip-select low in cycle 0", {31'd0, mac_csb_n}, 32'd0);
      repeat (9) @(negedge clk);
      rdc(3, 0, "R5 custom not finished at cycle 9");
      @(negedge clk);
      rdc(3, 1, "R5 custom finished at cycle 10");
      rdc(4, fmem[12], "R6 custom read word 12");

      // R9 enable masking
      wr(2, 2, 0);
      chk("R9 masked finish gives no interrupt", {31'd0, irq}, 32'd0);
      wr(2, 1, 0);
      chk("R9 enabled finish gives interrupt", {31'd0, irq}, 32'd1);

      repeat (3) @(negedge clk);
      done = 1;
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1;
         nchk++;
         nfail++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("%0d/%0d checks passed", nchk - nfail, nchk);
         $finish;
      end
   end
endmodule